// File: doc/BRIEF.md
# Programmable Width One-Shot Generator

This block turns the rising edge of a synchronous trigger into a single output pulse whose length is chosen by a 3-bit selector. After the trigger edge, a fixed start delay passes before the pulse rises. The pulse then stays high for a base width plus a step width times the selector value. All of these times are counted in clock cycles. The block drives a true output and a complementary output.

The selector is read live rather than captured at the trigger, so software or a neighbouring block must hold it stable while the pulse is high. Any trigger edge is ignored from the moment a pulse is accepted until a recovery window after the pulse has ended.

An active-low asynchronous reset aborts any phase in progress and forces the idle output levels. The start delay, base width and step width must be at least one cycle. The recovery time may be zero.

Top module: `pwos_gen`

## Requirements
- R1: A pulse is started only by a rising edge of `trig_i` seen in the idle phase. A trigger that stays high never starts a second pulse.
- R2: With the selector held at value A (0 to 7, read as an unsigned binary value of `addr_i`), `pulse_o` is high for exactly BASE_W + STEP_W × A consecutive cycles.
- R3: The pulse length never decreases as the selector value increases.
- R4: If the trigger edge is sampled on clock edge N, `pulse_o` first reads high after clock edge N + START_DLY.
- R5: Trigger edges that arrive while the pulse is high neither extend it nor start another pulse.
- R6: After `pulse_o` falls on clock edge M, trigger edges sampled on edges M+1 through M+RECOV_DLY are ignored. A trigger edge sampled on edge M+RECOV_DLY+1 is accepted.
- R7: The pulse ends on the first clock edge at which its elapsed high-cycle count is at least the width given by the current selector. Lowering the selector below the elapsed count ends the pulse on the next clock. Raising it lengthens the pulse.
- R8: `pulse_n_o` is always the complement of `pulse_o`.
- R9: While `rst_ni` is low, `pulse_o` is 0 and `pulse_n_o` is 1, and every delay, pulse or recovery phase is cleared. A trigger held high through reset does not fire. The next rising edge after reset is accepted immediately, even if reset arrived during recovery.
- R10: A trigger that is already high when the recovery window ends does not start a pulse. A new low-to-high transition is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; aborts any pulse |
| trig_i | input | 1 | Synchronous trigger; rising edge starts a pulse |
| addr_i | input | AW (3) | Width selector, read live during the pulse |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |

## Verification
Each of the eight selector values is fired once in ascending order. This separates a correct base-plus-step width from an off-by-one count, and shows that widths never shrink. Random selectors with trigger chatter during the pulse separate a block that ignores busy-time edges from one that restarts or extends the pulse. Trigger edges placed on the last cycle of recovery and on the first cycle after it pin down the exact length of the lockout. A trigger held high across recovery or reset is checked against a stale edge detector. Selector changes in mid-pulse, both downward past the elapsed count and upward, show that the end of the pulse follows the live selector and not a latched copy.

// File: rtl/pwos_pkg.sv
package pwos_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DELAY   = 2'd1,
    ST_PULSE   = 2'd2,
    ST_RECOVER = 2'd3
  } pwos_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwos_edge_det.sv
module pwos_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);

  logic trig_q;

  // Reset to 1 so a trigger held high across reset is not seen as an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b1;
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;

endmodule

// File: rtl/pwos_width_calc.sv
module pwos_width_calc #(
  parameter int BASE_W = 4,
  parameter int STEP_W = 2,
  parameter int AW     = 3,
  parameter int CW     = 5
) (
  input  logic [AW-1:0] addr_i,
  output logic [CW-1:0] width_o
);

  int width_full;

  always_comb begin
    width_full = BASE_W + STEP_W * int'(addr_i);
    width_o    = CW'(width_full);
  end

endmodule

// File: rtl/pwos_seq_ctrl.sv
module pwos_seq_ctrl
  import pwos_pkg::*;
#(
  parameter int START_DLY = 3,
  parameter int RECOV_DLY = 5,
  parameter int CW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic [CW-1:0] width_i,
  output logic          active_o
);

  localparam logic [CW-1:0] DLY_LIM = CW'(START_DLY);
  localparam logic [CW-1:0] REC_LIM = CW'(RECOV_DLY);
  localparam logic [CW-1:0] ONE     = CW'(1);

  pwos_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rise_i) begin
          state_d = ST_DELAY;
          cnt_d   = ONE;
        end
      end
      ST_DELAY: begin
        if (cnt_q >= DLY_LIM) begin
          state_d = ST_PULSE;
          cnt_d   = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_PULSE: begin
        // live width: compare elapsed count against current selector
        if (cnt_q >= width_i) begin
          if (RECOV_DLY == 0) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            state_d = ST_RECOVER;
            cnt_d   = ONE;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_RECOVER: begin
        if (cnt_q >= REC_LIM) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q == ST_PULSE);

  assert_edge_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rise_i) |=> (state_q == ST_DELAY));

  assert_delay_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY && cnt_q < DLY_LIM) |=> (state_q == ST_DELAY));

  assert_pulse_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE && cnt_q < width_i) |=> (state_q == ST_PULSE));

  assert_width_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULSE && cnt_q >= width_i) |=> (state_q != ST_PULSE));

  assert_recover_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER) |=> (state_q == ST_RECOVER || state_q == ST_IDLE));

endmodule

// File: rtl/pwos_gen.sv
module pwos_gen
  import pwos_pkg::*;
#(
  parameter int START_DLY = 3,
  parameter int BASE_W    = 4,
  parameter int STEP_W    = 2,
  parameter int RECOV_DLY = 5,
  parameter int AW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [AW-1:0] addr_i,
  output logic          pulse_o,
  output logic          pulse_n_o
);

  localparam int MAX_W = BASE_W + STEP_W * ((1 << AW) - 1);
  localparam int MAX_C = max3(START_DLY, MAX_W, RECOV_DLY);
  localparam int CW    = $clog2(MAX_C + 1);

  logic          rise;
  logic [CW-1:0] width;
  logic          active;

  pwos_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  pwos_width_calc #(
    .BASE_W (BASE_W),
    .STEP_W (STEP_W),
    .AW     (AW),
    .CW     (CW)
  ) u_width (
    .addr_i  (addr_i),
    .width_o (width)
  );

  pwos_seq_ctrl #(
    .START_DLY (START_DLY),
    .RECOV_DLY (RECOV_DLY),
    .CW        (CW)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .width_i  (width),
    .active_o (active)
  );

  assign pulse_o   = active;
  assign pulse_n_o = ~active;

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_o && pulse_n_o));

endmodule

// File: tb/pwos_gen_tb.sv
`timescale 1ns/1ps
module pwos_gen_tb;

  localparam int START_DLY = 3;
  localparam int BASE_W    = 4;
  localparam int STEP_W    = 2;
  localparam int RECOV_DLY = 5;
  localparam int AW        = 3;

  logic          clk;
  logic          rst_n;
  logic          trig;
  logic [AW-1:0] addr;
  logic          pulse, pulse_n;

  int n_checks = 0;
  int n_fail   = 0;

  pwos_gen #(
    .START_DLY (START_DLY),
    .BASE_W    (BASE_W),
    .STEP_W    (STEP_W),
    .RECOV_DLY (RECOV_DLY),
    .AW        (AW)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .trig_i    (trig),
    .addr_i    (addr),
    .pulse_o   (pulse),
    .pulse_n_o (pulse_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_width(input int a);
    return BASE_W + STEP_W * a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raise trigger, count low cycles before pulse and high cycles of pulse.
  // Returns at the first negedge where the pulse reads low again.
  task automatic fire(input int a, input bit chatter, output int dly, output int wid,
                      output bit cmpl_ok);
    @(negedge clk);
    addr = AW'(a);
    trig = 1'b1;
    dly = 0;
    wid = 0;
    cmpl_ok = 1'b1;
    @(negedge clk);
    while (!pulse && dly < 1000) begin
      dly++;
      trig = 1'b0;
      if (pulse_n !== ~pulse) cmpl_ok = 1'b0;
      @(negedge clk);
    end
    while (pulse && wid < 1000) begin
      wid++;
      if (pulse_n !== ~pulse) cmpl_ok = 1'b0;
      if (chatter) trig = ~trig;
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  task automatic settle();
    repeat (RECOV_DLY + 2) @(negedge clk);
  endtask

  initial begin
    #(20.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int dly, wid, prev, hi;
    bit ok;
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b1;
    trig  = 1'b0;
    addr  = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulse == 1'b0 && pulse_n == 1'b1, "R9 reset levels", int'(pulse), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4: sweep all selector values
    prev = 0;
    for (int a = 0; a < 8; a++) begin
      fire(a, 1'b0, dly, wid, ok);
      chk(dly == START_DLY, "R4 start delay", dly, START_DLY);
      chk(wid == exp_width(a), "R2 width", wid, exp_width(a));
      chk(wid >= prev, "R3 monotonic", wid, prev);
      chk(ok, "R8 complement", int'(ok), 1);
      prev = wid;
      settle();
    end

    // R5: random selectors with trigger chatter during the pulse
    for (int i = 0; i < 20; i++) begin
      int a;
      bit ch;
      a  = int'($urandom_range(7, 0));
      ch = 1'(($urandom() >> 3) & 1);
      fire(a, ch, dly, wid, ok);
      chk(wid == exp_width(a), "R5 width with chatter", wid, exp_width(a));
      chk(ok, "R8 complement", int'(ok), 1);
      hi = 0;
      repeat (RECOV_DLY + 2) begin
        if (pulse) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R5 no extra pulse after chatter", hi, 0);
    end

    // R1: held trigger gives a single pulse only
    fire(1, 1'b0, dly, wid, ok);
    settle();
    @(negedge clk);
    trig = 1'b1;
    hi = 0;
    wid = 0;
    repeat (START_DLY + exp_width(0) + RECOV_DLY + 40) begin
      @(negedge clk);
      if (pulse && !hi) wid++;
      if (!pulse && wid > 0) hi = 1;
      if (pulse && hi) hi = 2;
    end
    chk(wid == exp_width(addr) && hi != 2, "R1 held trigger single pulse", hi, 1);
    trig = 1'b0;
    settle();

    // R6 R10: edge on last recovery cycle is ignored, held high stays ignored
    fire(2, 1'b0, dly, wid, ok);
    repeat (RECOV_DLY - 1) @(negedge clk);
    trig = 1'b1;
    hi = 0;
    repeat (40) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    chk(hi == 0, "R6 edge in recovery ignored", hi, 0);
    chk(hi == 0, "R10 held trigger after recovery", hi, 0);
    trig = 1'b0;
    @(negedge clk);

    // R6: edge right after recovery window is accepted
    fire(2, 1'b0, dly, wid, ok);
    repeat (RECOV_DLY - 1) @(negedge clk);
    fire(3, 1'b0, dly, wid, ok);
    chk(dly == START_DLY, "R6 first edge after recovery delay", dly, START_DLY);
    chk(wid == exp_width(3), "R6 first edge after recovery width", wid, exp_width(3));
    settle();

    // R7: selector lowered below elapsed count ends pulse next clock
    @(negedge clk);
    addr = 3'd7;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (!pulse) @(negedge clk);
    wid = 0;
    while (pulse && wid < 1000) begin
      wid++;
      if (wid == 10) addr = 3'd1;
      @(negedge clk);
    end
    chk(wid == 10, "R7 shrink ends next clock", wid, 10);
    settle();

    // R7: selector raised mid-pulse lengthens it
    @(negedge clk);
    addr = 3'd0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (!pulse) @(negedge clk);
    wid = 0;
    while (pulse && wid < 1000) begin
      wid++;
      if (wid == 2) addr = 3'd3;
      @(negedge clk);
    end
    chk(wid == exp_width(3), "R7 grow extends pulse", wid, exp_width(3));
    settle();

    // R9: reset mid-pulse with trigger held high
    @(negedge clk);
    addr = 3'd7;
    trig = 1'b1;
    while (!pulse) @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pulse == 1'b0 && pulse_n == 1'b1, "R9 reset aborts pulse", int'(pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    hi = 0;
    repeat (40) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    chk(hi == 0, "R9 trigger held through reset ignored", hi, 0);
    trig = 1'b0;
    fire(4, 1'b0, dly, wid, ok);
    chk(dly == START_DLY, "R9 edge after reset accepted", dly, START_DLY);

    // R9: reset during recovery clears the lockout
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fire(5, 1'b0, dly, wid, ok);
    chk(dly == START_DLY, "R9 reset clears recovery", dly, START_DLY);
    chk(wid == exp_width(5), "R9 width after reset", wid, exp_width(5));
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule